// File: doc/BRIEF.md
# Chip-Select SRAM Access Sequencer

This block turns single host requests into the strobe sequence of one external chip-select area that holds asynchronous SRAM-style memory. A request (address, read or write, write data and a small area tag) is taken through a valid/ready handshake. The block then walks a fixed series of phases: an optional idle gap, address setup, chip-select lead, the strobe itself, chip-select trail and address hold. During the strobe it raises either the active-low read strobe or the active-low write enable. In the last strobe cycle of a read it captures the read data and returns it with a one-cycle response pulse.

Two configuration words set the timing. The timing word carries the setup, hold, strobe lead and trail fields, a bus-start hold bit and a 4-bit wait code. The wait code maps nonlinearly onto 0 to 25 extra strobe cycles. The gap word carries five idle-gap fields and the bus-width code. The gap field used for a request is picked from the kind of the previous access and the new one, and from whether the two area tags match. The timing word and the width are latched when a request is accepted. The gap is taken from the gap word at acceptance.

Top module: `cs_sram_seq`

## Requirements
- R1: While reset is low and right after it, req_ready_o is 1, bus_cs_no, bus_rd_no, bus_we_no and bus_bs_no are 1, and bus_aen_o and rsp_valid_o are 0.
- R2: With every timing and gap field at zero, bus_cs_no and the strobe go low in the cycle after acceptance, stay low for one cycle, and req_ready_o is 1 again in the next cycle.
- R3: The strobe stays low for 1 + N cycles. N comes from wait code cfg_timing_i[3:0]: codes 0 to 9 give N equal to the code, 10 to 13 give 2*code-9 (11, 13, 15, 17), 14 gives 21 and 15 gives 25.
- R4: bus_aen_o is high for setup cycles (cfg_timing_i[30:28]) before bus_cs_no falls, and for hold cycles (cfg_timing_i[26:24]) after it rises. bus_addr_o equals the request address and does not change while bus_aen_o is high.
- R5: On a read, bus_rd_no falls after cfg_timing_i[22:20] cycles of chip select. Chip select stays low for cfg_timing_i[18:16] cycles after bus_rd_no rises. bus_we_no stays 1.
- R6: On a write, bus_we_no falls after cfg_timing_i[14:12] cycles of chip select. Chip select stays low for cfg_timing_i[10:8] cycles after bus_we_no rises. bus_rd_no stays 1.
- R7: bus_bs_no goes low in the first chip-select cycle. It stays low for 1 cycle when cfg_timing_i[4] is 0 and for 2 cycles when it is 1, cut short when chip select ends earlier.
- R8: Between acceptance and the first cycle with bus_aen_o high, the block inserts an idle gap. Its length comes from cfg_gap_i as follows: after a write, [18:16]; read then write to a different area tag, [14:12]; read then write to the same tag, [10:8]; read then read to a different tag, [6:4]; read then read to the same tag, [2:0].
- R9: The first access after reset inserts no idle gap, whatever the gap fields hold.
- R10: req_ready_o is low from the cycle after acceptance through the last cycle of address hold, and is 1 in the cycle after that.
- R11: Bus width code cfg_gap_i[21:20] (1 = 8-bit, 2 = 16-bit, 3 or 0 = 32-bit) zeroes the unused upper bits of bus_wdata_o during the strobe and of rsp_rdata_o.
- R12: A read gives exactly one rsp_valid_o pulse, in the cycle after its last strobe cycle, carrying bus_rdata_i as sampled in that last strobe cycle. A write gives none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_area_i | input | AREA_W | Area tag of the request |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| cfg_timing_i | input | 32 | Timing word (setup, hold, strobe lead/trail, bus-start hold, wait code) |
| cfg_gap_i | input | 32 | Idle-gap fields and bus-width code |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W | Read data, width-masked |
| bus_addr_o | output | ADDR_W | External address |
| bus_aen_o | output | 1 | Address drive window |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_we_no | output | 1 | Write enable, active low |
| bus_bs_no | output | 1 | Bus-start pulse, active low |
| bus_wdata_o | output | DATA_W | External write data, width-masked |
| bus_rdata_i | input | DATA_W | External read data |

## Verification
The bench sweeps every wait code and every value of each 3-bit delay field. A decoder that got the upper wait codes wrong, or a sequencer that dropped a zero-length phase one cycle late, would show as a strobe or window one cycle too long or too short. A fixed sequence of access pairs walks all five gap-selection cases plus the first access after a mid-run reset. A selector that swapped the same-area and different-area fields, or kept the stale previous access across reset, would insert a wrong gap. The bus-start hold is tried against chip-select windows of 1 to 3 cycles, which catches a pulse that outlives chip select. All four width codes are applied to both reads and writes, which catches masking of the wrong byte lanes and a response raised on writes.

// File: rtl/cs_sram_pkg.sv
package cs_sram_pkg;
  localparam int CNT_W = 5;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_GAP   = 3'd1,
    PH_SETUP = 3'd2,
    PH_PRE   = 3'd3,
    PH_STRB  = 3'd4,
    PH_POST  = 3'd5,
    PH_HOLD  = 3'd6
  } phase_e;

  typedef struct packed {
    logic [2:0] ads;
    logic [2:0] adh;
    logic [2:0] rds;
    logic [2:0] rdh;
    logic [2:0] wts;
    logic [2:0] wth;
    logic       bsh;
    logic [3:0] wcode;
  } tim_t;
endpackage

// File: rtl/cs_wait_decode.sv
module cs_wait_decode (
  input  logic [3:0] code_i,
  output logic [4:0] cycles_o
);
  always_comb begin
    if (code_i < 4'd10)      cycles_o = {1'b0, code_i};
    else if (code_i < 4'd14) cycles_o = {code_i, 1'b0} - 5'd9;
    else if (code_i == 4'd14) cycles_o = 5'd21;
    else                     cycles_o = 5'd25;
  end
endmodule

// File: rtl/cs_gap_select.sv
module cs_gap_select #(
  parameter int AREA_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              wr_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic [2:0]        gap_wx_i,
  input  logic [2:0]        gap_rw_same_i,
  input  logic [2:0]        gap_rw_diff_i,
  input  logic [2:0]        gap_rr_same_i,
  input  logic [2:0]        gap_rr_diff_i,
  output logic [2:0]        gap_o
);
  logic              prev_vld_q;
  logic              prev_wr_q;
  logic [AREA_W-1:0] prev_area_q;
  logic              same_area;

  assign same_area = (area_i == prev_area_q);

  always_comb begin
    if (!prev_vld_q)    gap_o = 3'd0;
    else if (prev_wr_q) gap_o = gap_wx_i;
    else if (wr_i)      gap_o = same_area ? gap_rw_same_i : gap_rw_diff_i;
    else                gap_o = same_area ? gap_rr_same_i : gap_rr_diff_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vld_q  <= 1'b0;
      prev_wr_q   <= 1'b0;
      prev_area_q <= '0;
    end else if (accept_i) begin
      prev_vld_q  <= 1'b1;
      prev_wr_q   <= wr_i;
      prev_area_q <= area_i;
    end
  end
endmodule

// File: rtl/cs_phase_fsm.sv
module cs_phase_fsm
  import cs_sram_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] gap_i,
  input  logic [2:0] ads_i,
  input  logic [2:0] pre_i,
  input  logic [4:0] wait_i,
  input  logic [2:0] post_i,
  input  logic [2:0] adh_i,
  input  logic       bsh_i,
  output logic       idle_o,
  output logic       aen_o,
  output logic       cs_act_o,
  output logic       strb_act_o,
  output logic       strb_last_o,
  output logic       bs_act_o
);
  phase_e           phase_q, nxt;
  logic [CNT_W-1:0] cnt_q, ld;
  logic             advance;
  logic [1:0]       cs_age_q;
  logic             nz_gap, nz_ads, nz_pre, nz_post, nz_adh;

  assign nz_gap  = |gap_i;
  assign nz_ads  = |ads_i;
  assign nz_pre  = |pre_i;
  assign nz_post = |post_i;
  assign nz_adh  = |adh_i;

  // zero-length phases are skipped
  always_comb begin
    case (phase_q)
      PH_IDLE:  nxt = nz_gap ? PH_GAP : nz_ads ? PH_SETUP : nz_pre ? PH_PRE : PH_STRB;
      PH_GAP:   nxt = nz_ads ? PH_SETUP : nz_pre ? PH_PRE : PH_STRB;
      PH_SETUP: nxt = nz_pre ? PH_PRE : PH_STRB;
      PH_PRE:   nxt = PH_STRB;
      PH_STRB:  nxt = nz_post ? PH_POST : nz_adh ? PH_HOLD : PH_IDLE;
      PH_POST:  nxt = nz_adh ? PH_HOLD : PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      PH_GAP:   ld = {2'b00, gap_i} - 5'd1;
      PH_SETUP: ld = {2'b00, ads_i} - 5'd1;
      PH_PRE:   ld = {2'b00, pre_i} - 5'd1;
      PH_STRB:  ld = wait_i;
      PH_POST:  ld = {2'b00, post_i} - 5'd1;
      PH_HOLD:  ld = {2'b00, adh_i} - 5'd1;
      default:  ld = '0;
    endcase
  end

  assign advance = (phase_q == PH_IDLE) ? start_i : (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (advance) begin
      phase_q <= nxt;
      cnt_q   <= ld;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 5'd1;
    end
  end

  assign idle_o      = (phase_q == PH_IDLE);
  assign aen_o       = (phase_q != PH_IDLE) && (phase_q != PH_GAP);
  assign cs_act_o    = (phase_q == PH_PRE) || (phase_q == PH_STRB) || (phase_q == PH_POST);
  assign strb_act_o  = (phase_q == PH_STRB);
  assign strb_last_o = (phase_q == PH_STRB) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cs_age_q <= 2'd0;
    else if (!cs_act_o)                  cs_age_q <= 2'd0;
    else if (cs_age_q != 2'd2)           cs_age_q <= cs_age_q + 2'd1;
  end

  assign bs_act_o = cs_act_o && ((cs_age_q == 2'd0) || ((cs_age_q == 2'd1) && bsh_i));
endmodule

// File: rtl/cs_sram_seq.sv
module cs_sram_seq
  import cs_sram_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int AREA_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AREA_W-1:0] req_area_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [31:0]       cfg_timing_i,
  input  logic [31:0]       cfg_gap_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_aen_o,
  output logic              bus_cs_no,
  output logic              bus_rd_no,
  output logic              bus_we_no,
  output logic              bus_bs_no,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int BYTES = DATA_W / 8;

  tim_t              tim_live, tim_q, tim_use;
  logic              accept;
  logic              wr_q, wr_use;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, mask;
  logic [1:0]        width_q;
  logic              rsp_q;
  logic [2:0]        gap, pre_len, post_len;
  logic [4:0]        wait_cyc;
  logic              idle, aen, cs_act, strb_act, strb_last, bs_act;
  logic              unused_cfg;

  assign tim_live.ads   = cfg_timing_i[30:28];
  assign tim_live.adh   = cfg_timing_i[26:24];
  assign tim_live.rds   = cfg_timing_i[22:20];
  assign tim_live.rdh   = cfg_timing_i[18:16];
  assign tim_live.wts   = cfg_timing_i[14:12];
  assign tim_live.wth   = cfg_timing_i[10:8];
  assign tim_live.bsh   = cfg_timing_i[4];
  assign tim_live.wcode = cfg_timing_i[3:0];

  assign unused_cfg = ^{cfg_timing_i[31], cfg_timing_i[27], cfg_timing_i[23], cfg_timing_i[19],
                        cfg_timing_i[15], cfg_timing_i[11], cfg_timing_i[7:5],
                        cfg_gap_i[31:22], cfg_gap_i[19], cfg_gap_i[15], cfg_gap_i[11],
                        cfg_gap_i[7], cfg_gap_i[3]};

  assign req_ready_o = idle;
  assign accept      = req_valid_i && idle;

  // lengths come from the live word in the accept cycle, latched copy afterwards
  assign tim_use  = accept ? tim_live : tim_q;
  assign wr_use   = accept ? req_write_i : wr_q;
  assign pre_len  = wr_use ? tim_use.wts : tim_use.rds;
  assign post_len = wr_use ? tim_use.wth : tim_use.rdh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      width_q <= 2'd0;
    end else if (accept) begin
      tim_q   <= tim_live;
      wr_q    <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      width_q <= cfg_gap_i[21:20];
    end
  end

  cs_wait_decode u_wait (
    .code_i   (tim_use.wcode),
    .cycles_o (wait_cyc)
  );

  cs_gap_select #(.AREA_W(AREA_W)) u_gap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .accept_i      (accept),
    .wr_i          (req_write_i),
    .area_i        (req_area_i),
    .gap_wx_i      (cfg_gap_i[18:16]),
    .gap_rw_diff_i (cfg_gap_i[14:12]),
    .gap_rw_same_i (cfg_gap_i[10:8]),
    .gap_rr_diff_i (cfg_gap_i[6:4]),
    .gap_rr_same_i (cfg_gap_i[2:0]),
    .gap_o         (gap)
  );

  cs_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .gap_i       (gap),
    .ads_i       (tim_use.ads),
    .pre_i       (pre_len),
    .wait_i      (wait_cyc),
    .post_i      (post_len),
    .adh_i       (tim_use.adh),
    .bsh_i       (tim_use.bsh),
    .idle_o      (idle),
    .aen_o       (aen),
    .cs_act_o    (cs_act),
    .strb_act_o  (strb_act),
    .strb_last_o (strb_last),
    .bs_act_o    (bs_act)
  );

  // byte-lane mask from width code: 1 = 8, 2 = 16, 0/3 = full
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic keep;
    if (b == 0) begin : g_b0
      assign keep = 1'b1;
    end else if (b == 1) begin : g_b1
      assign keep = (width_q != 2'd1);
    end else begin : g_bn
      assign keep = (width_q == 2'd0) || (width_q == 2'd3);
    end
    assign mask[b*8 +: 8] = {8{keep}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= strb_last && !wr_q;
      if (strb_last && !wr_q) rdata_q <= bus_rdata_i & mask;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_aen_o   = aen;
  assign bus_cs_no   = ~cs_act;
  assign bus_rd_no   = ~(strb_act && !wr_q);
  assign bus_we_no   = ~(strb_act && wr_q);
  assign bus_bs_no   = ~bs_act;
  assign bus_wdata_o = wdata_q & mask;
endmodule

// File: rtl/cs_sram_seq_chk.sv
module cs_sram_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_aen_o,
  input logic              bus_cs_no,
  input logic              bus_rd_no,
  input logic              bus_we_no,
  input logic              bus_bs_no,
  input logic              rsp_valid_o
);
  AST_RD_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni) !bus_rd_no |-> !bus_cs_no); // R5
  AST_WE_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni) !bus_we_no |-> !bus_cs_no); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) bus_rd_no || bus_we_no); // R6
  AST_CS_INSIDE_AEN: assert property (@(posedge clk_i) disable iff (!rst_ni) !bus_cs_no |-> bus_aen_o); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (bus_aen_o && $past(bus_aen_o)) |-> $stable(bus_addr_o)); // R4
  AST_BS_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni) !bus_bs_no |-> !bus_cs_no); // R7
  AST_BS_AT_CS_START: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(bus_cs_no) |-> !bus_bs_no); // R7
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) req_ready_o |-> (bus_cs_no && !bus_aen_o)); // R10
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
  AST_RSP_AT_RD_END: assert property (@(posedge clk_i) disable iff (!rst_ni) rsp_valid_o |-> $rose(bus_rd_no)); // R12
endmodule

bind cs_sram_seq cs_sram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .bus_addr_o  (bus_addr_o),
  .bus_aen_o   (bus_aen_o),
  .bus_cs_no   (bus_cs_no),
  .bus_rd_no   (bus_rd_no),
  .bus_we_no   (bus_we_no),
  .bus_bs_no   (bus_bs_no),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/cs_sram_seq_bench.sv
module cs_sram_seq_bench;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [RW-1:0] req_area = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [31:0]   cfg_timing, cfg_gap;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_aen, bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n;

  logic [2:0] c_ads = 0, c_adh = 0, c_rds = 0, c_rdh = 0, c_wts = 0, c_wth = 0;
  logic       c_bsh = 0;
  logic [3:0] c_wc = 0;
  logic [2:0] g_rrs = 0, g_rrd = 0, g_rws = 0, g_rwd = 0, g_wx = 0;
  logic [1:0] c_width = 0;

  assign cfg_timing = {1'b0, c_ads, 1'b0, c_adh, 1'b0, c_rds, 1'b0, c_rdh,
                       1'b0, c_wts, 1'b0, c_wth, 3'b000, c_bsh, c_wc};
  assign cfg_gap    = {10'd0, c_width, 1'b0, g_wx, 1'b0, g_rwd, 1'b0, g_rws,
                       1'b0, g_rrd, 1'b0, g_rrs};
  assign bus_rdata  = {8'hA5, bus_addr};

  always #10 clk = ~clk;

  cs_sram_seq u_cs_sram_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_area_i(req_area), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cfg_timing_i(cfg_timing), .cfg_gap_i(cfg_gap),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .bus_aen_o(bus_aen), .bus_cs_no(bus_cs_n),
    .bus_rd_no(bus_rd_n), .bus_we_no(bus_we_n), .bus_bs_no(bus_bs_n),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  int n_vec = 0, n_bad = 0;
  int m_gap, m_setup, m_pre, m_strb, m_post, m_hold, m_bs, m_busy, m_rsp, m_wrong, m_addr_bad;
  logic [DW-1:0] m_rdata, m_wdata;
  bit p_vld = 0, p_wr = 0;
  logic [RW-1:0] p_area = '0;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkh(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wdec(input logic [3:0] c);
    if (c < 10) return int'(c);
    if (c < 14) return 2 * int'(c) - 9;
    if (c == 14) return 21;
    return 25;
  endfunction

  function automatic logic [DW-1:0] wmask(input logic [1:0] w);
    if (w == 2'd1) return 32'h0000_00FF;
    if (w == 2'd2) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ready in reset", int'(req_ready), 1);
    chk("R1 strobes in reset", int'({bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n}), 15);
    chk("R1 aen/rsp in reset", int'({bus_aen, rsp_valid}), 0);
    rst_n = 1'b1;
    p_vld = 0;
    @(negedge clk);
    chk("R1 idle after reset", int'({req_ready, bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n, bus_aen, rsp_valid}), 7'b1111100);
  endtask

  // starts and ends at a negedge
  task automatic access(input logic wr, input logic [RW-1:0] area, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd);
    bit seen_aen = 0, seen_cs = 0, seen_stb = 0;
    int guard = 0;
    logic stb, other;
    m_gap = 0; m_setup = 0; m_pre = 0; m_strb = 0; m_post = 0; m_hold = 0;
    m_bs = 0; m_busy = 0; m_rsp = 0; m_wrong = 0; m_addr_bad = 0; m_rdata = '0; m_wdata = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_area = area; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && guard < 300) begin
      guard++;
      m_busy++;
      stb   = wr ? !bus_we_n : !bus_rd_n;
      other = wr ? !bus_rd_n : !bus_we_n;
      if (other) m_wrong++;
      if (!seen_aen && !bus_aen) m_gap++;
      if (bus_aen) begin
        seen_aen = 1;
        if (bus_addr !== addr) m_addr_bad++;
      end
      if (bus_aen && bus_cs_n) begin
        if (!seen_cs) m_setup++; else m_hold++;
      end
      if (!bus_cs_n) begin
        seen_cs = 1;
        if (stb) begin m_strb++; seen_stb = 1; m_wdata = bus_wdata; end
        else if (seen_stb) m_post++;
        else m_pre++;
      end
      if (!bus_bs_n) m_bs++;
      if (rsp_valid) begin m_rsp++; m_rdata = rsp_rdata; end
      @(negedge clk);
    end
    if (rsp_valid) begin m_rsp++; m_rdata = rsp_rdata; end
    if (guard >= 300) chk("R10 access did not finish", guard, 0);
  endtask

  task automatic run(input logic wr, input logic [RW-1:0] area, input logic [AW-1:0] addr,
                     input logic [DW-1:0] wd);
    int eg, epre, epost, estrb, ecs, ebs;
    bit same;
    same  = (area == p_area);
    eg    = !p_vld ? 0 : p_wr ? int'(g_wx) :
            wr ? (same ? int'(g_rws) : int'(g_rwd)) : (same ? int'(g_rrs) : int'(g_rrd));
    epre  = wr ? int'(c_wts) : int'(c_rds);
    epost = wr ? int'(c_wth) : int'(c_rdh);
    estrb = 1 + wdec(c_wc);
    ecs   = epre + estrb + epost;
    ebs   = (ecs < 2 + int'(c_bsh)) ? ecs : 1 + int'(c_bsh);
    chk(p_vld ? "R8 idle gap" : "R9 first access gap", 0, 0);
    n_vec--;
    access(wr, area, addr, wd);
    chk(p_vld ? "R8 idle gap" : "R9 first access gap", m_gap, eg);
    p_vld = 1; p_wr = wr; p_area = area;
    chk("R4 setup cycles", m_setup, int'(c_ads));
    chk("R4 hold cycles", m_hold, int'(c_adh));
    chk("R4 address stable", m_addr_bad, 0);
    chk(wr ? "R6 cs to we" : "R5 cs to rd", m_pre, epre);
    chk(wr ? "R6 we to cs" : "R5 rd to cs", m_post, epost);
    chk(wr ? "R6 other strobe" : "R5 other strobe", m_wrong, 0);
    chk("R3 strobe length", m_strb, estrb);
    chk("R7 bus-start length", m_bs, ebs);
    chk("R10 busy cycles", m_busy, eg + int'(c_ads) + ecs + int'(c_adh));
    if (wr) begin
      chkh("R11 write data lanes", m_wdata, wd & wmask(c_width));
      chk("R12 no response on write", m_rsp, 0);
    end else begin
      chk("R12 one response", m_rsp, 1);
      chkh("R12 read data", m_rdata, {8'hA5, addr} & wmask(c_width));
    end
  endtask

  task automatic zero_cfg();
    c_ads = 0; c_adh = 0; c_rds = 0; c_rdh = 0; c_wts = 0; c_wth = 0; c_bsh = 0; c_wc = 0;
    g_rrs = 0; g_rrd = 0; g_rws = 0; g_rwd = 0; g_wx = 0; c_width = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog R10: actual hung expected completion");
    finish_run();
  end

  initial begin
    zero_cfg();
    do_reset();

    // R2: all-zero timing
    access(1'b0, 2'd0, 24'h000010, '0);
    chk("R2 cs/strobe in first cycle", m_gap + m_setup + m_pre, 0);
    chk("R2 strobe one cycle", m_strb, 1);
    chk("R2 ready after one cycle", m_busy, 1);
    p_vld = 1; p_wr = 0; p_area = 0;

    // R3: every wait code, read and write
    for (int c = 0; c < 16; c++) begin
      c_wc = 4'(c);
      run(1'b0, 2'd0, 24'h100 + 24'(c), '0);
      run(1'b1, 2'd0, 24'h200 + 24'(c), 32'h1234_5678 + 32'(c));
    end
    c_wc = 0;

    // R4: setup and hold
    for (int i = 0; i < 8; i++) begin
      c_ads = 3'(i); c_adh = 3'((i * 3) % 8);
      run(1'b0, 2'd1, 24'hABC000 + 24'(i), '0);
      run(1'b1, 2'd1, 24'h0F0F00 + 24'(i), 32'h0BAD_F00D);
    end
    c_ads = 0; c_adh = 0;

    // R5: read strobe lead and trail
    c_wc = 4'd2;
    for (int i = 0; i < 8; i++) begin
      c_rds = 3'(i); c_rdh = 3'(7 - i);
      run(1'b0, 2'd2, 24'h333300 + 24'(i), '0);
    end
    c_rds = 0; c_rdh = 0;

    // R6: write strobe lead and trail
    for (int i = 0; i < 8; i++) begin
      c_wts = 3'(i); c_wth = 3'((i + 5) % 8);
      run(1'b1, 2'd2, 24'h444400 + 24'(i), 32'h1111_1111 * 32'(i));
    end
    c_wts = 0; c_wth = 0; c_wc = 0;

    // R7: bus-start hold against short chip-select windows
    for (int b = 0; b < 2; b++) begin
      c_bsh = 1'(b);
      for (int k = 0; k < 3; k++) begin
        c_rds = 3'(k); c_wts = 3'(k);
        run(1'b0, 2'd3, 24'h555500 + 24'(k), '0);
        run(1'b1, 2'd3, 24'h555580 + 24'(k), 32'hFEED_0000 + 32'(k));
      end
    end
    c_bsh = 0; c_rds = 0; c_wts = 0;

    // R8, R9: gap selection after a fresh reset
    g_rrs = 3'd1; g_rrd = 3'd2; g_rws = 3'd3; g_rwd = 3'd4; g_wx = 3'd5;
    do_reset();
    run(1'b0, 2'd0, 24'h600000, '0);
    run(1'b0, 2'd0, 24'h600001, '0);
    run(1'b0, 2'd1, 24'h600002, '0);
    run(1'b1, 2'd1, 24'h600003, 32'hA1A1_A1A1);
    run(1'b1, 2'd1, 24'h600004, 32'hB2B2_B2B2);
    run(1'b0, 2'd2, 24'h600005, '0);
    run(1'b1, 2'd3, 24'h600006, 32'hC3C3_C3C3);
    run(1'b0, 2'd3, 24'h600007, '0);
    run(1'b0, 2'd3, 24'h600008, '0);
    run(1'b0, 2'd0, 24'h600009, '0);
    run(1'b1, 2'd0, 24'h60000A, 32'hD4D4_D4D4);
    c_ads = 3'd2; c_adh = 3'd1;
    run(1'b0, 2'd2, 24'h60000B, '0);
    run(1'b1, 2'd1, 24'h60000C, 32'hE5E5_E5E5);
    zero_cfg();

    // R11: bus width codes
    for (int w = 0; w < 4; w++) begin
      c_width = 2'(w);
      run(1'b1, 2'd0, 24'h123456, 32'hCAFE_F00D);
      run(1'b0, 2'd0, 24'h89ABCD, '0);
    end

    finish_run();
  end
endmodule